// File: doc/BRIEF.md
# SPI Controller Status, Interrupt and Chip-Select Registers

This block is the register front end of a FIFO-based SPI controller. It holds the transmit and receive FIFOs and the control, configuration and interrupt-enable registers. It builds a status word from two sources. Some flags follow the FIFO occupancy live. Two flags are sticky and record events until software writes ones to clear them. A single level interrupt is raised whenever an enabled status bit is set. The shift engine sits outside the block. It pops transmit words, pushes received words and pulses a completion strobe. In return the block gives it the transmit FIFO head, the rounded burst length in bits and a flush pulse.

Software reaches the block over a simple 32-bit bus with separate read and write strobes. Writes take effect at the clock edge. Read data is combinational for the addressed register. The word offsets are: received data 0x00, transmit data 0x04, control 0x08, configuration 0x0C, interrupt enable 0x10, status 0x18.

Control register fields are: bit 0 enable, bits [4 +: channel count] per-channel controller mode, bits [12 +: select width] channel select, and bits [31:20] burst length minus one. Chip selects are active low, one per channel. They are reloaded only on a control-register write.

Top module: `spi_status_regs`

## Requirements
- R1: After reset, status reads 0x00000003, and control, configuration and interrupt enable read 0. All cs_n lines are high, irq is low and eng_tx_avail is low.
- R2: Status bit 0 is set while the TX FIFO is empty. Bit 1 is set while TX occupancy is at most half the depth. Bit 2 is set while the TX FIFO is full. A write to transmit data while the FIFO is full is dropped. Words leave on eng_tx_data in write order.
- R3: Status bit 3 is set while the RX FIFO holds a word. Bit 4 is set while the RX FIFO is full.
- R4: A push from the engine while the RX FIFO is full drops the word and sets sticky status bit 6. Bit 6 stays set until a status write with bit 6 equal to 1. A status write with bit 6 equal to 0 leaves it set.
- R5: An eng_burst_done pulse sets sticky status bit 7. A status write with bit 7 equal to 1 clears it. If a set and a clear arrive in the same cycle, the bit ends up set.
- R6: irq is high exactly when the bitwise AND of status and interrupt enable is non-zero.
- R7: Reading received data returns the oldest RX word and removes it. A read while the RX FIFO is empty returns 0 and changes nothing. A write to the received-data offset has no effect.
- R8: On a control write, cs_n[i] goes low only when the written enable bit is 1 and i equals the written channel select. Otherwise cs_n[i] goes high. chan_master takes the written mode bit of the selected channel. Both hold between control writes.
- R9: A control write that changes enable from 1 to 0 empties both FIFOs and clears status bit 6. Status bit 7 is kept. eng_flush is high for exactly the one cycle after that write. A control write while enable is already 0 gives no pulse.
- R10: eng_burst_bits equals the burst field plus one, rounded up to the next multiple of 8.
- R11: The control, configuration and interrupt-enable registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Level interrupt |
| cs_n | output | 4 | Active-low chip selects |
| chan_master | output | 1 | Controller mode of the selected channel |
| eng_burst_bits | output | 13 | Rounded burst length in bits |
| eng_flush | output | 1 | One-cycle pulse after the controller is disabled |
| eng_tx_pop | input | 1 | Engine takes the TX head word |
| eng_tx_data | output | 32 | TX FIFO head word |
| eng_tx_avail | output | 1 | TX FIFO not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_burst_done | input | 1 | Burst completion pulse |

## Verification
The TX FIFO is filled past half depth and then to full, which separates the three live TX flags. A push attempted while full shows that the extra word is dropped. The RX FIFO is pushed past full so that the overflow word can be told apart from the kept words by the order of read-back. A read on empty is then done, and status writes with zero and one bits show the difference between sticky and live flags. A completion pulse is placed in the same cycle as its clearing write to show which wins. The enable is dropped with both FIFOs loaded and both sticky flags set, which shows what a flush clears and what it keeps. Control writes with several burst fields, including 0, 7, 8 and the maximum, check the rounding at each boundary.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int BL_W = 12;
  localparam int ST_W = 8;

  localparam logic [7:0] OFS_RXD  = 8'h00;
  localparam logic [7:0] OFS_TXD  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_CFG  = 8'h0C;
  localparam logic [7:0] OFS_IEN  = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h18;

  localparam int ST_TXE  = 0;
  localparam int ST_TXLO = 1;
  localparam int ST_TXF  = 2;
  localparam int ST_RXR  = 3;
  localparam int ST_RXF  = 4;
  localparam int ST_OVF  = 6;
  localparam int ST_DONE = 7;

  localparam int CT_EN       = 0;
  localparam int CT_MODE_LSB = 4;
  localparam int CT_SEL_LSB  = 12;
  localparam int CT_BL_LSB   = 20;

  typedef enum logic [2:0] {
    RS_NONE, RS_RXD, RS_TXD, RS_CTRL, RS_CFG, RS_IEN, RS_STAT
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_RXD:  return RS_RXD;
      OFS_TXD:  return RS_TXD;
      OFS_CTRL: return RS_CTRL;
      OFS_CFG:  return RS_CFG;
      OFS_IEN:  return RS_IEN;
      OFS_STAT: return RS_STAT;
      default:  return RS_NONE;
    endcase
  endfunction

  function automatic logic [BL_W:0] round_burst(input logic [BL_W-1:0] field);
    logic [BL_W:0] n;
    n = {1'b0, field} + 1'b1;
    return (n + (BL_W+1)'(7)) & ~((BL_W+1)'(7));
  endfunction
endpackage

// File: rtl/spi_sr_fifo.sv
module spi_sr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign do_push = push && (count != CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/spi_sr_flags.sv
module spi_sr_flags
  import spi_sr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              ovf_evt,
  input  logic              done_evt,
  input  logic              flush,
  input  logic [ST_W-1:0]   clr,
  input  logic [DATA_W-1:0] ien,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  logic ovf_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (flush)            ovf_q <= 1'b0;
      else if (ovf_evt)     ovf_q <= 1'b1;
      else if (clr[ST_OVF]) ovf_q <= 1'b0;

      if (done_evt)          done_q <= 1'b1;
      else if (clr[ST_DONE]) done_q <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_TXE]  = (tx_count == '0);
    status[ST_TXLO] = (tx_count <= CNT_W'(DEPTH / 2));
    status[ST_TXF]  = (tx_count == CNT_W'(DEPTH));
    status[ST_RXR]  = (rx_count != '0);
    status[ST_RXF]  = (rx_count == CNT_W'(DEPTH));
    status[ST_OVF]  = ovf_q;
    status[ST_DONE] = done_q;
  end

  assign irq = |(status & ien);
endmodule

// File: rtl/spi_sr_csdec.sv
module spi_sr_csdec #(
  parameter int NUM_CS = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_CS-1:0] mode,
  output logic [NUM_CS-1:0] cs_n,
  output logic              master
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cs_n[i] <= 1'b1;
      else if (load) cs_n[i] <= !(en && (sel == SEL_W'(i)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    master <= 1'b0;
    else if (load) master <= mode[sel];
  end
endmodule

// File: rtl/spi_status_regs.sv
module spi_status_regs
  import spi_sr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int NUM_CS     = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic [NUM_CS-1:0] cs_n,
  output logic              chan_master,
  output logic [BL_W:0]     eng_burst_bits,
  output logic              eng_flush,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_data,
  output logic              eng_tx_avail,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_burst_done
);
  reg_sel_e          rsel;
  logic              wr_txd, wr_ctrl, wr_cfg, wr_ien, wr_stat, rd_rxd;
  logic [DATA_W-1:0] ctrl_q, cfg_q, ien_q;
  logic [DATA_W-1:0] status_w, rx_head;
  logic [CNT_W-1:0]  tx_count, rx_count;
  logic              flush_now, rx_full_w, ovf_evt;
  logic [ST_W-1:0]   stat_clr;

  assign rsel    = decode_ofs(bus_addr);
  assign wr_txd  = bus_wr && (rsel == RS_TXD);
  assign wr_ctrl = bus_wr && (rsel == RS_CTRL);
  assign wr_cfg  = bus_wr && (rsel == RS_CFG);
  assign wr_ien  = bus_wr && (rsel == RS_IEN);
  assign wr_stat = bus_wr && (rsel == RS_STAT);
  assign rd_rxd  = bus_rd && (rsel == RS_RXD);

  assign flush_now = wr_ctrl && ctrl_q[CT_EN] && !bus_wdata[CT_EN];
  assign rx_full_w = (rx_count == CNT_W'(FIFO_DEPTH));
  assign ovf_evt   = eng_rx_push && rx_full_w;
  assign stat_clr  = wr_stat ? bus_wdata[ST_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cfg_q     <= '0;
      ien_q     <= '0;
      eng_flush <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_cfg)  cfg_q  <= bus_wdata;
      if (wr_ien)  ien_q  <= bus_wdata;
      eng_flush <= flush_now;
    end
  end

  spi_sr_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush_now),
    .push(wr_txd), .din(bus_wdata),
    .pop(eng_tx_pop), .dout(eng_tx_data), .count(tx_count)
  );

  spi_sr_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush_now),
    .push(eng_rx_push), .din(eng_rx_data),
    .pop(rd_rxd), .dout(rx_head), .count(rx_count)
  );

  spi_sr_flags #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .tx_count(tx_count), .rx_count(rx_count),
    .ovf_evt(ovf_evt), .done_evt(eng_burst_done),
    .flush(flush_now), .clr(stat_clr), .ien(ien_q),
    .status(status_w), .irq(irq)
  );

  spi_sr_csdec #(.NUM_CS(NUM_CS)) u_cs (
    .clk(clk), .rst_n(rst_n), .load(wr_ctrl),
    .en(bus_wdata[CT_EN]),
    .sel(bus_wdata[CT_SEL_LSB +: SEL_W]),
    .mode(bus_wdata[CT_MODE_LSB +: NUM_CS]),
    .cs_n(cs_n), .master(chan_master)
  );

  assign eng_tx_avail   = (tx_count != '0);
  assign eng_burst_bits = round_burst(ctrl_q[CT_BL_LSB +: BL_W]);

  always_comb begin
    case (rsel)
      RS_RXD:  bus_rdata = (rx_count != '0) ? rx_head : '0;
      RS_CTRL: bus_rdata = ctrl_q;
      RS_CFG:  bus_rdata = cfg_q;
      RS_IEN:  bus_rdata = ien_q;
      RS_STAT: bus_rdata = status_w;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_status_regs_chk.sv
module spi_status_regs_chk
  import spi_sr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_addr,
  input logic              wdata_ovf_bit,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [NUM_CS-1:0] cs_n,
  input logic              eng_flush,
  input logic              eng_burst_done,
  input logic              flush_now,
  input logic [7:0]        status_lo,
  input logic [DATA_W-1:0] ien_q
);
  a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  a_r8_hold_between_writes: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_CTRL) |=> $stable(cs_n));

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    eng_burst_done |=> status_lo[ST_DONE]);

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_lo[ST_OVF] && !flush_now && !(bus_wr && bus_addr == OFS_STAT && wdata_ovf_bit))
      |=> status_lo[ST_OVF]);

  a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_RXD && !status_lo[ST_RXR]) |-> (bus_rdata == '0));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> (status_lo[6:0] == 7'h03));

  a_r9_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> eng_flush);
endmodule

bind spi_status_regs spi_status_regs_chk #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .wdata_ovf_bit(bus_wdata[6]),
  .bus_rdata(bus_rdata), .irq(irq), .cs_n(cs_n),
  .eng_flush(eng_flush), .eng_burst_done(eng_burst_done),
  .flush_now(flush_now), .status_lo(status_w[7:0]), .ien_q(ien_q)
);

// File: tb/sim_spi_status_regs.sv
module sim_spi_status_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [3:0]  cs_n;
  logic        chan_master;
  logic [12:0] eng_burst_bits;
  logic        eng_flush;
  logic        eng_tx_pop = 1'b0;
  logic [31:0] eng_tx_data;
  logic        eng_tx_avail;
  logic        eng_rx_push = 1'b0;
  logic [31:0] eng_rx_data = '0;
  logic        eng_burst_done = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  localparam logic [7:0] A_RXD = 8'h00, A_TXD = 8'h04, A_CTRL = 8'h08,
                         A_CFG = 8'h0C, A_IEN = 8'h10, A_STAT = 8'h18;

  always #5 clk = ~clk;

  spi_status_regs u0 (.*);

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] obs;
  event        obs_ev;

  initial forever begin
    @(obs_ev);
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL scoreboard: read with no expected item, got %h", obs);
    end else begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (obs !== e) begin
        errors++;
        $display("FAIL %s: read %h expected %h", t, obs, e);
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 obs = bus_rdata;
    -> obs_ev;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic tx_take(input logic [31:0] e, input string t);
    @(negedge clk);
    chk(t, eng_tx_data, e);
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    eng_burst_done = 1'b1;
    @(negedge clk);
    eng_burst_done = 1'b0;
  endtask

  function automatic logic [12:0] want_bits(input int field);
    int n;
    n = field + 1;
    return 13'(((n + 7) / 8) * 8);
  endfunction

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", {28'h0, cs_n}, 32'hF);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx_avail", {31'h0, eng_tx_avail}, 32'h0);
    rd_expect(A_STAT, 32'h3, "R1 status");
    rd_expect(A_CTRL, 32'h0, "R1 ctrl");
    rd_expect(A_CFG, 32'h0, "R1 cfg");
    rd_expect(A_IEN, 32'h0, "R1 ien");

    // R11 readback
    wr(A_CFG, 32'hA5A5_1234);
    rd_expect(A_CFG, 32'hA5A5_1234, "R11 cfg");

    // R8 / R10 chip select and burst rounding
    wr(A_CTRL, 32'h00C0_2041);
    chk("R8 cs_n sel2", {28'h0, cs_n}, 32'hB);
    chk("R8 master", {31'h0, chan_master}, 32'h1);
    chk("R10 burst 12", {19'h0, eng_burst_bits}, {19'h0, want_bits(12)});
    rd_expect(A_CTRL, 32'h00C0_2041, "R11 ctrl");
    wr(A_CTRL, 32'h0000_0001);
    chk("R8 cs_n sel0", {28'h0, cs_n}, 32'hE);
    chk("R8 master off", {31'h0, chan_master}, 32'h0);
    chk("R10 burst 0", {19'h0, eng_burst_bits}, {19'h0, want_bits(0)});
    wr(A_CTRL, 32'hFFF0_0001);
    chk("R10 burst max", {19'h0, eng_burst_bits}, {19'h0, want_bits(4095)});
    wr(A_CTRL, 32'h0070_0001);
    chk("R10 burst 7", {19'h0, eng_burst_bits}, {19'h0, want_bits(7)});
    wr(A_CTRL, 32'h0080_0001);
    chk("R10 burst 8", {19'h0, eng_burst_bits}, {19'h0, want_bits(8)});
    wr(A_CTRL, 32'h00C0_2041);

    // R2 TX flags and ordering
    for (int i = 0; i < 4; i++) wr(A_TXD, 32'h7000_0000 + i);
    rd_expect(A_STAT, 32'h02, "R2 half");
    wr(A_TXD, 32'h7000_0004);
    rd_expect(A_STAT, 32'h00, "R2 above half");
    for (int i = 5; i < 8; i++) wr(A_TXD, 32'h7000_0000 + i);
    rd_expect(A_STAT, 32'h04, "R2 full");
    wr(A_TXD, 32'hDEAD_BEEF);
    for (int i = 0; i < 8; i++) tx_take(32'h7000_0000 + i, "R2 tx order");
    chk("R2 tx drained", {31'h0, eng_tx_avail}, 32'h0);
    rd_expect(A_STAT, 32'h03, "R2 empty again");

    // R3 / R4 / R7 RX path
    for (int i = 0; i < 3; i++) rx_push(32'h5000_0000 + i);
    rd_expect(A_STAT, 32'h0B, "R3 ready");
    rd_expect(A_RXD, 32'h5000_0000, "R7 pop first");
    for (int i = 3; i < 9; i++) rx_push(32'h5000_0000 + i);
    rd_expect(A_STAT, 32'h1B, "R3 full");
    rx_push(32'hBAD0_0000);
    rd_expect(A_STAT, 32'h5B, "R4 overflow set");
    for (int i = 1; i < 9; i++) rd_expect(A_RXD, 32'h5000_0000 + i, "R4 kept words");
    rd_expect(A_STAT, 32'h43, "R4 sticky after drain");
    rd_expect(A_RXD, 32'h0, "R7 empty read");
    rd_expect(A_STAT, 32'h43, "R7 empty read no change");
    wr(A_STAT, 32'h0);
    rd_expect(A_STAT, 32'h43, "R4 zero write keeps");
    wr(A_STAT, 32'h40);
    rd_expect(A_STAT, 32'h03, "R4 cleared");
    wr(A_RXD, 32'h1234_5678);
    rd_expect(A_STAT, 32'h03, "R7 write ignored status");
    rd_expect(A_RXD, 32'h0, "R7 write ignored data");

    // R5 transfer complete
    done_pulse();
    rd_expect(A_STAT, 32'h83, "R5 set");
    wr(A_STAT, 32'h80);
    rd_expect(A_STAT, 32'h03, "R5 cleared");
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h80; eng_burst_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_burst_done = 1'b0;
    rd_expect(A_STAT, 32'h83, "R5 set wins");
    wr(A_STAT, 32'h80);

    // R6 interrupt
    wr(A_IEN, 32'h80);
    chk("R6 masked low", {31'h0, irq}, 32'h0);
    done_pulse();
    chk("R6 done irq", {31'h0, irq}, 32'h1);
    wr(A_STAT, 32'h80);
    chk("R6 cleared irq", {31'h0, irq}, 32'h0);
    wr(A_IEN, 32'h01);
    chk("R6 tx empty irq", {31'h0, irq}, 32'h1);
    wr(A_TXD, 32'h1111_2222);
    chk("R6 tx loaded irq", {31'h0, irq}, 32'h0);
    tx_take(32'h1111_2222, "R2 single");
    rd_expect(A_IEN, 32'h01, "R11 ien");
    wr(A_IEN, 32'h0);

    // R9 flush on disable
    for (int i = 0; i < 3; i++) wr(A_TXD, 32'h3000_0000 + i);
    for (int i = 0; i < 9; i++) rx_push(32'h4000_0000 + i);
    done_pulse();
    rd_expect(A_STAT, 32'hDA, "R9 loaded");
    wr(A_CTRL, 32'h00C0_2040);
    chk("R9 flush pulse", {31'h0, eng_flush}, 32'h1);
    chk("R9 cs released", {28'h0, cs_n}, 32'hF);
    chk("R9 tx emptied", {31'h0, eng_tx_avail}, 32'h0);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'h0, eng_flush}, 32'h0);
    rd_expect(A_STAT, 32'h83, "R9 status after flush");
    rd_expect(A_RXD, 32'h0, "R9 rx emptied");
    wr(A_CTRL, 32'h0);
    chk("R9 no pulse when off", {31'h0, eng_flush}, 32'h0);

    repeat (2) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule